// File: doc/BRIEF.md
# Dual-Group Configurable Clock Divider

This block takes one fast clock and produces two related, phase-aligned output clocks. The divider normally runs from an oscillator. When a test bit is set, a reference clock replaces the oscillator and drives the same divide logic. A two-bit select code picks the ratio of the first group (A): 4, 5 or 6 source cycles per period. The second group (B) always runs at half the rate of group A. Each rising edge of B falls on a rising edge of A.

The select and test inputs pass through a synchroniser in the divider clock domain. When either of them changes, the phase counter restarts from zero with both outputs low, so no shortened pulse can appear. A valid flag reports that the outputs are running. The fourth select code is reserved. It parks both outputs low and drops the valid flag.

Top module: `dual_group_clk_div`

## Requirements
- R1: Select code {fsel_i[1], fsel_i[0]} = 00, 01 or 10 gives group A a period of 4, 5 or 6 divider source cycles.
- R2: Group B has a period of twice the group A ratio, and is high for exactly one group A ratio of cycles (50/50).
- R3: Group A is high for the ratio divided by two, rounded down: 2 of 4, 2 of 5 (40/60) and 3 of 6 cycles.
- R4: Group B rises only in a cycle in which group A also rises, and it does so on every second group A rising edge.
- R5: Select code 11 keeps grp_a_o, grp_b_o and valid_o low for as long as it stays active.
- R6: With test_i high, the divider is clocked by ref_clk_i instead of osc_clk_i, so the outputs count reference cycles.
- R7: A new value on fsel_i or test_i takes effect after two divider clock edges. On that edge the counter restarts, and all outputs are low in the following cycle.
- R8: valid_o goes high on the first rising edge of group B after a reset or a restart. It stays high until the next restart, until code 11 becomes active, or until reset.
- R9: While rst_ni is low, all outputs are low. After release, the first rising edges of A and B occur on the same source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast oscillator clock, the normal divider source |
| ref_clk_i | input | 1 | Reference clock, the divider source in test mode |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsel_i | input | 2 | Ratio select code (11 reserved) |
| test_i | input | 1 | Selects ref_clk_i as the divider source when high |
| grp_a_o | output | 1 | Group A clock, source divided by 4, 5 or 6 |
| grp_b_o | output | 1 | Group B clock, source divided by 8, 10 or 12 |
| valid_o | output | 1 | Outputs are running with a valid ratio |

## Verification
The bench uses the default parameters: a base ratio of 4, three usable codes and a two-stage synchroniser. These settings cover every ratio in the table, including the odd ratio and its 40/60 group A waveform, as well as the reserved code. The bench also switches the divider source from the oscillator to the reference and back. The oscillator and the reference have different periods, so a source swap shows up in the measured waveforms. Code changes, source swaps and a reset in the middle of a run exercise the restart sequence and the point at which the valid flag rises again.

// File: rtl/dgcd_pkg.sv
`timescale 1ns/1ps
package dgcd_pkg;
  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic             test;
    logic [SEL_W-1:0] sel;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/dgcd_clk_sel.sv
`timescale 1ns/1ps
module dgcd_clk_sel (
  input  logic osc_clk_i,
  input  logic ref_clk_i,
  input  logic test_i,
  output logic clk_o
);
  // bypass path: reference drives the divider directly
  assign clk_o = test_i ? ref_clk_i : osc_clk_i;
endmodule

// File: rtl/dgcd_cfg_sync.sv
`timescale 1ns/1ps
module dgcd_cfg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         restart_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 2) begin : g_two
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[0], d_i};
      end
    end else begin : g_deep
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o       = stg_q[STAGES-1];
  // active config is about to change on this edge
  assign restart_o = stg_q[STAGES-1] != stg_q[STAGES-2];
endmodule

// File: rtl/dgcd_phase_gen.sv
`timescale 1ns/1ps
module dgcd_phase_gen #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned DIV_MIN = 4,
  parameter int unsigned N_MODES = 3,
  localparam int unsigned DIV_MAX = DIV_MIN + N_MODES - 1,
  localparam int unsigned CW      = $clog2(2 * DIV_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             grp_a_o,
  output logic             grp_b_o,
  output logic             valid_o
);
  logic          known;
  logic [CW-1:0] ratio, half_hi, last_cnt, mod_cnt, cnt_q;
  logic          a_q, b_q, v_q, b_nxt;

  always_comb begin
    known    = 32'(sel_i) < N_MODES;
    ratio    = known ? (CW'(DIV_MIN) + CW'(sel_i)) : '0;
    half_hi  = ratio >> 1;
    last_cnt = (ratio << 1) - CW'(1);
    mod_cnt  = (cnt_q >= ratio) ? (cnt_q - ratio) : cnt_q;
    b_nxt    = cnt_q < ratio;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      v_q   <= 1'b0;
    end else if (restart_i || !known) begin
      cnt_q <= '0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      v_q   <= 1'b0;
    end else begin
      a_q <= mod_cnt < half_hi;
      b_q <= b_nxt;
      if (b_nxt && !b_q) v_q <= 1'b1;
      cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + CW'(1);
    end
  end

  assign grp_a_o = a_q;
  assign grp_b_o = b_q;
  assign valid_o = v_q;
endmodule

// File: rtl/dual_group_clk_div.sv
`timescale 1ns/1ps
module dual_group_clk_div
  import dgcd_pkg::*;
#(
  parameter int unsigned DIV_MIN     = 4,
  parameter int unsigned N_MODES     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             osc_clk_i,
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] fsel_i,
  input  logic             test_i,
  output logic             grp_a_o,
  output logic             grp_b_o,
  output logic             valid_o
);
  logic             div_clk;
  cfg_t             cfg_in, cfg_act;
  logic             restart;
  logic [SEL_W-1:0] sel_act;

  assign cfg_in.test = test_i;
  assign cfg_in.sel  = fsel_i;

  dgcd_clk_sel u_clk_sel (
    .osc_clk_i (osc_clk_i),
    .ref_clk_i (ref_clk_i),
    .test_i    (test_i),
    .clk_o     (div_clk)
  );

  dgcd_cfg_sync #(.STAGES(SYNC_STAGES), .W(CFG_W)) u_sync (
    .clk_i     (div_clk),
    .rst_ni    (rst_ni),
    .d_i       (cfg_in),
    .q_o       (cfg_act),
    .restart_o (restart)
  );

  assign sel_act = cfg_act.sel;

  dgcd_phase_gen #(.SEL_W(SEL_W), .DIV_MIN(DIV_MIN), .N_MODES(N_MODES)) u_gen (
    .clk_i     (div_clk),
    .rst_ni    (rst_ni),
    .sel_i     (sel_act),
    .restart_i (restart),
    .grp_a_o   (grp_a_o),
    .grp_b_o   (grp_b_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/dgcd_chk.sv
`timescale 1ns/1ps
module dgcd_chk #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned DIV_MIN = 4,
  parameter int unsigned N_MODES = 3,
  localparam int unsigned DIV_MAX  = DIV_MIN + N_MODES - 1,
  localparam int unsigned A_HI_MAX = DIV_MAX / 2,
  localparam int unsigned RW       = $clog2(DIV_MAX + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic [SEL_W-1:0] sel_act_i,
  input logic             grp_a_i,
  input logic             grp_b_i,
  input logic             valid_i
);
  logic [RW-1:0] a_run_q, b_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_run_q <= '0;
      b_run_q <= '0;
    end else begin
      a_run_q <= grp_a_i ? ((a_run_q == '1) ? a_run_q : a_run_q + RW'(1)) : '0;
      b_run_q <= grp_b_i ? ((b_run_q == '1) ? b_run_q : b_run_q + RW'(1)) : '0;
    end
  end

  p_a_high_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(a_run_q) <= A_HI_MAX);

  p_b_high_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(b_run_q) <= DIV_MAX);

  p_b_rise_on_a_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grp_b_i) |-> $rose(grp_a_i));

  p_reserved_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sel_act_i) >= N_MODES) |=> (!grp_a_i && !grp_b_i && !valid_i));

  p_restart_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!grp_a_i && !grp_b_i && !valid_i));

  p_valid_with_b_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $rose(grp_b_i));
endmodule

bind dual_group_clk_div dgcd_chk #(
  .SEL_W(dgcd_pkg::SEL_W), .DIV_MIN(DIV_MIN), .N_MODES(N_MODES)
) u_chk (
  .clk_i     (div_clk),
  .rst_ni    (rst_ni),
  .restart_i (restart),
  .sel_act_i (sel_act),
  .grp_a_i   (grp_a_o),
  .grp_b_i   (grp_b_o),
  .valid_i   (valid_o)
);

// File: tb/dual_group_clk_div_tb_top.sv
`timescale 1ns/1ps
module dual_group_clk_div_tb_top;
  logic       osc_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       test    = 1'b0;
  logic [1:0] fsel    = 2'd0;
  logic       grp_a, grp_b, valid;

  int    n_run  = 0;
  int    n_fail = 0;
  string scen   = "R9 in reset";

  always #2.5 osc_clk = ~osc_clk;  // 200 MHz
  always #4   ref_clk = ~ref_clk;  // slower reference

  wire dclk = test ? ref_clk : osc_clk;

  dual_group_clk_div dut_i (
    .osc_clk_i (osc_clk),
    .ref_clk_i (ref_clk),
    .rst_ni    (rst_n),
    .fsel_i    (fsel),
    .test_i    (test),
    .grp_a_o   (grp_a),
    .grp_b_o   (grp_b),
    .valid_o   (valid)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", scen, what, act, exp, $time);
    end
  endtask

  // behavioural reference: two-edge config delay, phase count from restart
  logic [2:0] m_s1 = 3'd0, m_s2 = 3'd0;
  int   m_cnt = 0;
  logic m_a = 1'b0, m_b = 1'b0, m_v = 1'b0;

  always @(posedge dclk or negedge rst_n) begin
    int   n;
    logic nb;
    if (!rst_n) begin
      m_s1 = 3'd0; m_s2 = 3'd0; m_cnt = 0;
      m_a = 1'b0; m_b = 1'b0; m_v = 1'b0;
    end else begin
      n = (m_s2[1:0] == 2'd3) ? 0 : 4 + int'(m_s2[1:0]);
      if ((m_s1 != m_s2) || n == 0) begin
        m_cnt = 0; m_a = 1'b0; m_b = 1'b0; m_v = 1'b0;
      end else begin
        nb  = m_cnt < n;
        m_a = (m_cnt % n) < (n / 2);
        if (nb && !m_b) m_v = 1'b1;
        m_b = nb;
        m_cnt = (m_cnt == 2 * n - 1) ? 0 : m_cnt + 1;
      end
      m_s2 = m_s1;
      m_s1 = {test, fsel};
    end
    #1;
    chk("grp_a", grp_a, m_a);
    chk("grp_b", grp_b, m_b);
    chk("valid", valid, m_v);
  end

  // stimulus lands 0.2 ns into a 40 ns frame where both clocks are low
  task automatic slot();
    longint t;
    t = longint'($realtime * 10.0);
    #(real'(400 - (t % 400) + 2) / 10.0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) slot();
  endtask

  initial begin
    run(2);
    // R9: reset state observed directly
    chk("R9 grp_a in reset", grp_a, 1'b0);
    chk("R9 grp_b in reset", grp_b, 1'b0);
    chk("R9 valid in reset", valid, 1'b0);
    scen = "R9 R1 R2 R3 R4 R8 ratio4";
    rst_n = 1'b1;
    run(8);
    scen = "R7 R1 R2 R3 R4 R8 ratio5";
    fsel = 2'd1;
    run(8);
    scen = "R7 R1 R2 R3 R4 R8 ratio6";
    fsel = 2'd2;
    run(8);
    scen = "R5 R7 reserved";
    fsel = 2'd3;
    run(4);
    chk("R5 grp_a parked", grp_a, 1'b0);
    chk("R5 grp_b parked", grp_b, 1'b0);
    chk("R5 valid dropped", valid, 1'b0);
    scen = "R8 R7 leave reserved";
    fsel = 2'd0;
    run(6);
    scen = "R6 R7 R3 ref ratio5";
    test = 1'b1;
    fsel = 2'd1;
    run(10);
    scen = "R6 R2 R4 ref ratio6";
    fsel = 2'd2;
    run(8);
    scen = "R6 R7 back to oscillator";
    test = 1'b0;
    fsel = 2'd0;
    run(6);
    scen = "R9 mid-run reset";
    fsel = 2'd2;
    run(2);
    rst_n = 1'b0;
    run(1);
    chk("R9 grp_a after async reset", grp_a, 1'b0);
    chk("R9 valid after async reset", valid, 1'b0);
    rst_n = 1'b1;
    run(6);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL R9 watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule